// File: doc/BRIEF.md
# Visibility Channel Transpose Multiplexer

This block sits behind a bank of parallel correlation accumulators. There are M lanes, one for each unique input pair: M = N(N+1)/2 for N correlator inputs. In every integration period each lane emits a burst of C results, one for each frequency channel, in channel order. The block merges these lanes onto a single stream and turns the data around. It reads one word from lane 0, then one from lane 1, and so on through lane M-1, and then starts again. The output therefore presents all the lanes of channel 0 as a single block, then all the lanes of channel 1, and so on.

Every lane is held in its own FIFO, C words deep. Output starts as soon as the lane whose turn it is holds a word. The arbiter never skips a lane, so the lane order holds even when the lanes arrive skewed in time. Each input word carries a complex value, with the real half above the imaginary half. On output the two halves are split into separate zero-extended fields. The output also carries the lane index, block start and end markers, and a sync marker once every SYNC_BLOCKS blocks. The merged stream carries one word per clock, so the integration length is raised to at least M. The accumulator width follows from that effective length.

Top module: `vis_transpose_mux`

## Requirements
- R1: The lane count is LANES = NUM_INPUTS*(NUM_INPUTS+1)/2. The effective integration length is KEFF = max(INTEG_LEN, LANES). The half-word width is ACC_W = ceil(log2(KEFF*(2^SAMPLE_W-1))). Lane i occupies in_data bits [i*2*ACC_W +: 2*ACC_W], with the real part in the upper ACC_W bits and the imaginary part in the lower ACC_W bits.
- R2: Each lane keeps every word that arrives while its buffer holds fewer than CHANNELS words. No such word is lost, and words leave each lane in arrival order.
- R3: Output words rotate through lanes 0,1,..,LANES-1 and then wrap, one word per lane per turn. A full set of simultaneous lane bursts therefore comes out channel by channel, each channel as lanes 0..LANES-1.
- R4: When the lane whose turn it is holds no word, the block waits on that lane and does not skip it. out_valid stays low while it waits, even if other lanes hold data.
- R5: A word written into the lane whose turn it is, and whose buffer was empty, appears with out_valid high after the next rising clock edge. It does not appear after the writing edge itself.
- R6: out_re and out_im carry the real and imaginary halves of the word, zero-extended to OUT_W bits.
- R7: out_lane gives the index of the lane the current output word came from.
- R8: out_sop is high on the first word of every LANES-word output block and out_eop on the last. Both are low whenever out_valid is low.
- R9: out_sync is high together with out_sop on block 0 after reset and then on every SYNC_BLOCKS-th block. It is never high without out_sop.
- R10: A word written into a lane whose buffer is full, with no read from it in the same cycle, is dropped. overflow_err then goes high and stays high until reset.
- R11: Synchronous active-high reset empties all lanes, returns the rotation to lane 0, restarts the block and sync counts, clears overflow_err and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Per-lane word strobe |
| in_data | input | LANES*2*ACC_W | Packed per-lane complex words, real half high |
| out_valid | output | 1 | Output word present |
| out_sop | output | 1 | First word of a block |
| out_eop | output | 1 | Last word of a block |
| out_sync | output | 1 | Periodic sync marker on a block start |
| out_lane | output | max(1,clog2(LANES)) | Source lane of the output word |
| out_re | output | OUT_W | Real part, zero-extended |
| out_im | output | OUT_W | Imaginary part, zero-extended |
| overflow_err | output | 1 | Sticky lane overflow flag |

## Verification
The hardest case to reach is the arbiter stalled on an empty lane while later lanes hold data or even overflow. Simultaneous bursts never produce it. The bench creates it in two ways. In the first, it skews the bursts so that lane 0 arrives last, and the rotation has to wait while every other lane is already filled. In the second, it fills a single non-zero lane past its depth while lane 0 stays empty. It then releases lane 0 with a single word and checks that exactly two words come out, in lane order, with the exact latency.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

   function automatic int vtm_lanes(input int n_inputs);
      return n_inputs * (n_inputs + 1) / 2;
   endfunction

   function automatic int vtm_keff(input int integ, input int lanes);
      return (integ > lanes) ? integ : lanes;
   endfunction

   function automatic int vtm_acc_w(input int keff, input int sample_w);
      longint prod;
      prod = longint'(keff) * ((longint'(1) << sample_w) - 1);
      return $clog2(prod);
   endfunction

   function automatic int vtm_idx_w(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   typedef enum logic [1:0] {
      VTM_POS_MID   = 2'b00,
      VTM_POS_FIRST = 2'b01,
      VTM_POS_LAST  = 2'b10,
      VTM_POS_ONLY  = 2'b11
   } vtm_pos_e;

endpackage

// File: rtl/vtm_lane_fifo.sv
module vtm_lane_fifo
   import vtm_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int DEPTH = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             overflow
);
   localparam int AW = vtm_idx_w(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 1) else $error("lane fifo depth must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;
   logic             accept;

   assign accept   = push && ((count < CW'(DEPTH)) || pop);
   assign overflow = push && !accept;
   assign empty    = (count == '0);
   assign rdata    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (accept) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (pop)    rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         case ({accept, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
      count <= CW'(DEPTH));

   assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);

endmodule

// File: rtl/vtm_rr_arbiter.sv
module vtm_rr_arbiter
   import vtm_pkg::*;
#(
   parameter int LANES = 3
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [LANES-1:0]            lane_empty,
   output logic [LANES-1:0]            lane_pop,
   output logic [vtm_idx_w(LANES)-1:0] grant,
   output logic                        take
);
   localparam int LW = vtm_idx_w(LANES);

   logic [LW-1:0] ptr;

   assign grant = ptr;
   assign take  = !lane_empty[ptr];

   for (genvar g = 0; g < LANES; g++) begin : g_pop
      assign lane_pop[g] = take && (ptr == LW'(g));
   end

   always_ff @(posedge clk) begin
      if (rst)       ptr <= '0;
      else if (take) ptr <= (ptr == LW'(LANES - 1)) ? '0 : ptr + 1'b1;
   end

   assert_single_pop_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(lane_pop));

   assert_hold_on_empty_R4: assert property (@(posedge clk) disable iff (rst)
      !take |=> $stable(ptr));

endmodule

// File: rtl/vtm_framer.sv
module vtm_framer
   import vtm_pkg::*;
#(
   parameter int LANES       = 3,
   parameter int SYNC_BLOCKS = 10
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     word_take,
   output vtm_pos_e word_pos,
   output logic     block_sync
);
   localparam int WW = vtm_idx_w(LANES);
   localparam int BW = vtm_idx_w(SYNC_BLOCKS);

   initial begin
      assert (SYNC_BLOCKS >= 1) else $error("sync period must be at least one block");
   end

   logic [WW-1:0] wcnt;
   logic [BW-1:0] bcnt;
   logic          first_w, last_w;

   assign first_w    = (wcnt == '0);
   assign last_w     = (wcnt == WW'(LANES - 1));
   assign word_pos   = vtm_pos_e'({last_w, first_w});
   assign block_sync = first_w && (bcnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         wcnt <= '0;
         bcnt <= '0;
      end else if (word_take) begin
         if (last_w) begin
            wcnt <= '0;
            bcnt <= (bcnt == BW'(SYNC_BLOCKS - 1)) ? '0 : bcnt + 1'b1;
         end else begin
            wcnt <= wcnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/vis_transpose_mux.sv
module vis_transpose_mux
   import vtm_pkg::*;
#(
   parameter int NUM_INPUTS  = 4,
   parameter int CHANNELS    = 64,
   parameter int SAMPLE_W    = 16,
   parameter int INTEG_LEN   = 55,
   parameter int SYNC_BLOCKS = 10,
   parameter int OUT_W       = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic [vtm_lanes(NUM_INPUTS)-1:0] in_valid,
   input  logic [vtm_lanes(NUM_INPUTS)*2*vtm_acc_w(vtm_keff(INTEG_LEN, vtm_lanes(NUM_INPUTS)), SAMPLE_W)-1:0] in_data,
   output logic out_valid,
   output logic out_sop,
   output logic out_eop,
   output logic out_sync,
   output logic [vtm_idx_w(vtm_lanes(NUM_INPUTS))-1:0] out_lane,
   output logic [OUT_W-1:0] out_re,
   output logic [OUT_W-1:0] out_im,
   output logic overflow_err
);
   localparam int LANES  = vtm_lanes(NUM_INPUTS);
   localparam int KEFF   = vtm_keff(INTEG_LEN, LANES);
   localparam int ACC_W  = vtm_acc_w(KEFF, SAMPLE_W);
   localparam int WORD_W = 2 * ACC_W;
   localparam int LW     = vtm_idx_w(LANES);

   initial begin
      assert (NUM_INPUTS >= 1) else $error("need at least one correlator input");
      assert (CHANNELS >= 1) else $error("need at least one channel");
      assert (SAMPLE_W >= 1 && SAMPLE_W <= 40) else $error("sample width out of range");
      assert (OUT_W >= ACC_W) else $error("output field narrower than accumulator width");
   end

   logic [LANES-1:0]  lane_empty, lane_pop, lane_ovf;
   logic [WORD_W-1:0] lane_head [LANES];
   logic [LW-1:0]     grant;
   logic              take;
   vtm_pos_e          word_pos;
   logic              block_sync;
   logic [WORD_W-1:0] head;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      vtm_lane_fifo #(
         .WIDTH (WORD_W),
         .DEPTH (CHANNELS)
      ) fifo_i (
         .clk      (clk),
         .rst      (rst),
         .push     (in_valid[g]),
         .wdata    (in_data[g*WORD_W +: WORD_W]),
         .pop      (lane_pop[g]),
         .rdata    (lane_head[g]),
         .empty    (lane_empty[g]),
         .overflow (lane_ovf[g])
      );
   end

   vtm_rr_arbiter #(.LANES(LANES)) arb_i (
      .clk        (clk),
      .rst        (rst),
      .lane_empty (lane_empty),
      .lane_pop   (lane_pop),
      .grant      (grant),
      .take       (take)
   );

   vtm_framer #(.LANES(LANES), .SYNC_BLOCKS(SYNC_BLOCKS)) frm_i (
      .clk        (clk),
      .rst        (rst),
      .word_take  (take),
      .word_pos   (word_pos),
      .block_sync (block_sync)
   );

   assign head = lane_head[grant];

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         out_sop      <= 1'b0;
         out_eop      <= 1'b0;
         out_sync     <= 1'b0;
         out_lane     <= '0;
         out_re       <= '0;
         out_im       <= '0;
         overflow_err <= 1'b0;
      end else begin
         out_valid    <= take;
         out_sop      <= take && word_pos[0];
         out_eop      <= take && word_pos[1];
         out_sync     <= take && block_sync;
         overflow_err <= overflow_err | (|lane_ovf);
         if (take) begin
            out_lane <= grant;
            out_re   <= OUT_W'(head[WORD_W-1:ACC_W]);
            out_im   <= OUT_W'(head[ACC_W-1:0]);
         end
      end
   end

   assert_sop_lane0_R8: assert property (@(posedge clk) disable iff (rst)
      out_sop |-> (out_lane == '0));

   assert_eop_lastlane_R8: assert property (@(posedge clk) disable iff (rst)
      out_eop |-> (out_lane == LW'(LANES - 1)));

   assert_marks_need_valid_R8: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> !(out_sop || out_eop || out_sync));

   assert_sync_on_sop_R9: assert property (@(posedge clk) disable iff (rst)
      out_sync |-> out_sop);

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      overflow_err |=> overflow_err);

endmodule

// File: tb/vis_transpose_mux_tb_top.sv
`timescale 1ns/1ps
module vis_transpose_mux_tb_top;
   localparam int N   = 3;
   localparam int C   = 8;
   localparam int SW  = 8;
   localparam int K   = 4;
   localparam int SB  = 10;
   localparam int OW  = 16;
   localparam int M   = N * (N + 1) / 2;   // 6 lanes
   localparam int A   = 11;                // ceil(log2(max(4,6)*255)) = 11 (R1)
   localparam int W2  = 2 * A;
   localparam int LW  = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [M-1:0]    in_valid = '0;
   logic [M*W2-1:0] in_data  = '0;
   logic out_valid, out_sop, out_eop, out_sync, overflow_err;
   logic [LW-1:0] out_lane;
   logic [OW-1:0] out_re, out_im;

   int tests = 0;
   int fails = 0;
   int k     = 0;
   bit mon_en = 1'b0;

   always #10 clk = ~clk;

   vis_transpose_mux #(
      .NUM_INPUTS(N), .CHANNELS(C), .SAMPLE_W(SW), .INTEG_LEN(K),
      .SYNC_BLOCKS(SB), .OUT_W(OW)
   ) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
      .out_sync(out_sync), .out_lane(out_lane), .out_re(out_re),
      .out_im(out_im), .overflow_err(overflow_err)
   );

   function automatic int re_of(input int b, input int ln, input int ch);
      return (b * 151 + ln * 37 + ch * 11 + 5) & ((1 << A) - 1);
   endfunction
   function automatic int im_of(input int b, input int ln, input int ch);
      return (b * 7 + ln * 53 + ch * 29 + 1 + 1024) & ((1 << A) - 1);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst) k = 0;
      else if (mon_en && out_valid) begin
         int b, ch, ln;
         bit is_sop, is_eop, is_sync;
         b  = k / (M * C);
         ch = (k / M) % C;
         ln = k % M;
         is_sop  = (ln == 0);
         is_eop  = (ln == M - 1);
         is_sync = is_sop && ((k / M) % SB == 0);
         chk(out_lane == LW'(ln), "R3/R7 lane order", out_lane, ln);
         chk(out_re == OW'(re_of(b, ln, ch)), "R6 real part", out_re, re_of(b, ln, ch));
         chk(out_im == OW'(im_of(b, ln, ch)), "R6 imag part", out_im, im_of(b, ln, ch));
         chk(out_sop == is_sop, "R8 sop", out_sop, is_sop);
         chk(out_eop == is_eop, "R8 eop", out_eop, is_eop);
         chk(out_sync == is_sync, "R9 sync", out_sync, is_sync);
         k = k + 1;
      end
   end

   task automatic do_reset();
      rst = 1'b1;
      in_valid = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic drive_burst(input int b, input int stag);
      int span;
      span = C + stag * (M - 1);
      for (int t = 0; t < span; t++) begin
         for (int i = 0; i < M; i++) begin
            int ch;
            ch = t - stag * (M - 1 - i);
            if (ch >= 0 && ch < C) begin
               in_valid[i] = 1'b1;
               in_data[i*W2 +: W2] = {A'(re_of(b, i, ch)), A'(im_of(b, i, ch))};
            end else begin
               in_valid[i] = 1'b0;
            end
         end
         @(negedge clk);
      end
      in_valid = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R11: reset state
      chk(out_valid == 1'b0, "R11 valid after reset", out_valid, 0);
      chk({out_sop, out_eop, out_sync} == 3'b000, "R11 marks after reset", {out_sop, out_eop, out_sync}, 0);
      chk(out_re == '0 && out_im == '0 && out_lane == '0, "R11 data after reset", out_re, 0);
      chk(overflow_err == 1'b0, "R11 error after reset", overflow_err, 0);

      // R1/R2/R3: three simultaneous bursts, sync across 24 blocks
      mon_en = 1'b1;
      for (int b = 0; b < 3; b++) begin
         drive_burst(b, 0);
         repeat (M * C + 4) @(negedge clk);
         chk(k == (b + 1) * M * C, "R2 word count after burst", k, (b + 1) * M * C);
      end
      chk(overflow_err == 1'b0, "R10 no error on legal bursts", overflow_err, 0);

      // R4: skewed bursts, lane 0 arriving last
      do_reset();
      chk(k == 0, "R11 restart count", k, 0);
      drive_burst(0, 3);
      repeat (M * C + 4) @(negedge clk);
      chk(k == M * C, "R4 word count skewed", k, M * C);
      mon_en = 1'b0;

      // R10/R4/R5: fill lane 1 beyond depth while lane 0 is empty
      do_reset();
      for (int ch = 0; ch <= C; ch++) begin
         in_valid = '0;
         in_valid[1] = 1'b1;
         in_data[1*W2 +: W2] = {A'(re_of(0, 1, ch)), A'(im_of(0, 1, ch))};
         @(negedge clk);
         if (ch == C - 1)
            chk(overflow_err == 1'b0, "R10 no error at exactly full", overflow_err, 0);
         chk(out_valid == 1'b0, "R4 wait on empty lane 0", out_valid, 0);
      end
      in_valid = '0;
      chk(overflow_err == 1'b1, "R10 error on overfill", overflow_err, 1);
      repeat (5) @(negedge clk);
      chk(overflow_err == 1'b1, "R10 error sticky", overflow_err, 1);
      chk(out_valid == 1'b0, "R4 still waiting", out_valid, 0);
      in_valid[0] = 1'b1;
      in_data[0 +: W2] = {A'(re_of(0, 0, 3)), A'(im_of(0, 0, 3))};
      @(negedge clk);
      in_valid = '0;
      chk(out_valid == 1'b0, "R5 not visible after write edge", out_valid, 0);
      @(negedge clk);
      chk(out_valid == 1'b1 && out_lane == 0, "R5 lane 0 word after next edge", out_lane, 0);
      chk(out_re == OW'(re_of(0, 0, 3)), "R5 lane 0 data", out_re, re_of(0, 0, 3));
      chk(out_sop == 1'b1 && out_sync == 1'b1, "R9 first block sync", out_sync, 1);
      @(negedge clk);
      chk(out_valid == 1'b1 && out_lane == 1, "R3 lane 1 follows", out_lane, 1);
      chk(out_re == OW'(re_of(0, 1, 0)), "R2 oldest lane 1 word kept", out_re, re_of(0, 1, 0));
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 stall on empty lane 2", out_valid, 1'b0);
      do_reset();
      chk(overflow_err == 1'b0, "R11 reset clears error", overflow_err, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule